// File: doc/BRIEF.md
# Four-Channel Converter Register Slave over SPI

This block is the device side of a serial register interface for a four-channel output converter. A host sends fixed 24-bit frames over a mode-0 SPI link. Each frame is either a write, which updates one register, or a read, which selects one register for return. The block keeps, for every channel, a code register, a gain trim, an offset trim, a slew setting and a converter control word. It also keeps two shared settings: a main configuration word and a supply-regulator configuration word. A software command produces a one-cycle strobe. All stored values are presented on parallel output ports so that the surrounding logic can use them.

Read data is not returned inside the read frame. The register selected by a read is captured when that frame ends, and it is shifted out in the low 16 bits of the next complete frame. A host usually sends a no-operation word as that next frame. Two reads sent back to back form a pipeline. The read address map differs from the write address map. The serial inputs are resynchronised into the system clock, so the serial clock must be several times slower than the system clock.

Top module: `qdac_spi_regs`

## Requirements
- R1: A frame is exactly 24 bits, MSB first, with cs_n low for the whole frame (SPI mode 0: mosi sampled on the rising sclk edge, miso updated on the falling edge). Bit 23 set means read. Bits 20:16 are the address and bits 15:0 are the data. Bits 22:21 are ignored.
- R2: A write frame to address ch (0..3) loads the channel code register. Address 0x08+ch loads the gain trim and 0x10+ch loads the offset trim, all from bits 15:0. Write addresses 0x04..0x07 and 0x0C..0x0F change nothing.
- R3: A write frame to address 0x1C+ch is a control write. Bits 15:13 select the target and bits 12:0 are the payload. Select 0 loads the slew setting of channel ch and select 2 loads the converter control of channel ch. Select 1 loads the shared main word and select 3 loads the shared regulator word.
- R4: A control write with select 4 pulses sw_pulse_o for one cycle with the payload on sw_val_o and stores nothing. Selects 5..7 change nothing.
- R5: A read frame uses this address map: 0x00+ch code, 0x04+ch control, 0x08+ch gain, 0x0C+ch offset, 0x14+ch slew, 0x18 the status_in port, 0x19 main, 0x1A regulator. The 13-bit words are zero-extended to 16 bits.
- R6: The value selected by a read frame is returned in bits 15:0 of the next complete frame, and bits 23:16 of that frame are zero. Consecutive reads pipeline: each frame returns the value selected by the frame before it.
- R7: A complete frame that follows a write frame returns all zeros. The first frame after reset also returns all zeros.
- R8: The word 0x1CE000 changes no register, gives no strobe and returns any pending read data.
- R9: A frame with fewer or more than 24 sclk rising edges is discarded. It writes nothing, and it neither consumes nor replaces pending read data.
- R10: After reset every register output is zero, and miso is low while cs_n is high.
- R11: Reads of 0x10..0x13 (the clear codes, which are not writable here) and of 0x1B..0x1F return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock, idle low |
| cs_n | input | 1 | Frame select, active low |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host |
| status_in | input | 16 | Value returned by a status read |
| data_o | output | 64 | Code registers, channel c at bits 16c+15:16c |
| gain_o | output | 64 | Gain trims, same packing |
| offset_o | output | 64 | Offset trims, same packing |
| dac_ctrl_o | output | 52 | Converter control words, channel c at bits 13c+12:13c |
| slew_o | output | 52 | Slew settings, same packing |
| main_o | output | 13 | Shared main configuration |
| dcdc_o | output | 13 | Shared regulator configuration |
| sw_pulse_o | output | 1 | One-cycle strobe for a software command |
| sw_val_o | output | 13 | Payload of the software command |

## Verification
Writes go to every channel with distinct values. This shows whether the channel index is decoded or whether writes spread into neighbouring channels. Control writes cover each select value, including the unused ones, so a select decode that is off by one changes the wrong output. Reads are made both singly, each followed by a no-operation, and back to back. This separates a value returned one frame late from one returned in the read frame or two frames late. Short and overlong frames are placed between a read and its collection, to show that a discarded frame neither writes nor consumes the pending value.

// File: rtl/qdac_pkg.sv
// Shared constants and types for the four-channel register slave.
// Assumes the address map is fixed at four channels (2-bit channel index).
package qdac_pkg;
    localparam int NCH      = 4;
    localparam int CH_W     = 2;
    localparam int FRAME_W  = 24;
    localparam int DATA_W   = 16;
    localparam int PAY_W    = 13;
    localparam int ADDR_W   = 5;
    localparam int RD_BIT   = 23;
    localparam int ADDR_LSB = 16;
    localparam int SEL_LSB  = 13;

    typedef enum logic [2:0] {
        SUB_SLEW = 3'd0,
        SUB_MAIN = 3'd1,
        SUB_DAC  = 3'd2,
        SUB_DCDC = 3'd3,
        SUB_SW   = 3'd4
    } sub_sel_e;

    localparam logic [ADDR_W-1:0] WA_GAIN = 5'h08;
    localparam logic [ADDR_W-1:0] WA_OFFS = 5'h10;
    localparam logic [ADDR_W-1:0] WA_CTRL = 5'h1C;

    localparam logic [ADDR_W-1:0] RA_STATUS = 5'h18;
    localparam logic [ADDR_W-1:0] RA_MAIN   = 5'h19;
    localparam logic [ADDR_W-1:0] RA_DCDC   = 5'h1A;

    localparam logic [FRAME_W-1:0] NOP_WORD = 24'h1CE000;
endpackage

// File: rtl/qdac_spi_sync.sv
// Brings sclk, cs_n and mosi into the clk domain and marks their edges.
// Assumes sclk half-periods span at least STAGES+2 clk cycles; STAGES >= 2.
module qdac_spi_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic mosi,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_act,
    output logic cs_start,
    output logic cs_end,
    output logic mosi_s
);
    logic [STAGES:0]   sclk_p;
    logic [STAGES:0]   csn_p;
    logic [STAGES-1:0] mosi_p;

    // Synchroniser chains, one extra stage on sclk/cs_n for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_p <= '0;
            csn_p  <= '1;
            mosi_p <= '0;
        end else begin
            sclk_p <= {sclk_p[STAGES-1:0], sclk};
            csn_p  <= {csn_p[STAGES-1:0], cs_n};
            mosi_p <= {mosi_p[STAGES-2:0], mosi};
        end
    end

    assign sclk_rise = sclk_p[STAGES-1] & ~sclk_p[STAGES];
    assign sclk_fall = ~sclk_p[STAGES-1] & sclk_p[STAGES];
    assign cs_act    = ~csn_p[STAGES-1];
    assign cs_start  = ~csn_p[STAGES-1] & csn_p[STAGES];
    assign cs_end    = csn_p[STAGES-1] & ~csn_p[STAGES];
    assign mosi_s    = mosi_p[STAGES-1];
endmodule

// File: rtl/qdac_frame_shift.sv
// Collects one serial frame and shifts one reply word out.
// Reports a frame only when exactly FRAME_W bits arrived before cs_n rose.
module qdac_frame_shift #(
    parameter int FRAME_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk_rise,
    input  logic               sclk_fall,
    input  logic               cs_act,
    input  logic               cs_start,
    input  logic               cs_end,
    input  logic               mosi_s,
    input  logic [FRAME_W-1:0] tx_word,
    output logic               frame_v,
    output logic [FRAME_W-1:0] frame_q,
    output logic               miso
);
    localparam int CNT_W   = $clog2(FRAME_W + 2);
    localparam int CNT_SAT = FRAME_W + 1;

    logic [FRAME_W-1:0] rx_sr;
    logic [FRAME_W-1:0] tx_sr;
    logic [CNT_W-1:0]   bit_cnt;

    // Receive shifter with saturating bit counter; frame reported at cs end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_sr   <= '0;
            bit_cnt <= '0;
            frame_v <= 1'b0;
            frame_q <= '0;
        end else begin
            frame_v <= 1'b0;
            if (cs_start) begin
                bit_cnt <= '0;
            end else if (cs_end) begin
                frame_v <= (bit_cnt == CNT_W'(FRAME_W));
                frame_q <= rx_sr;
            end else if (cs_act && sclk_rise) begin
                rx_sr <= {rx_sr[FRAME_W-2:0], mosi_s};
                if (bit_cnt != CNT_W'(CNT_SAT))
                    bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    // Transmit shifter: load at cs start, advance on each falling sclk edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sr <= '0;
            miso  <= 1'b0;
        end else if (cs_start) begin
            tx_sr <= tx_word;
            miso  <= tx_word[FRAME_W-1];
        end else if (!cs_act) begin
            miso  <= 1'b0;
        end else if (sclk_fall && bit_cnt != '0) begin
            tx_sr <= {tx_sr[FRAME_W-2:0], 1'b0};
            miso  <= tx_sr[FRAME_W-2];
        end
    end

    // R9: the counter never runs past its saturation value
    a_r9_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_W'(CNT_SAT));

    // R10: miso stays low once the frame select has been idle for a cycle
    a_r10_miso_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_act && $past(!cs_act)) |-> !miso);

    // R1: a reported frame is a single-cycle event
    a_r1_frame_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        frame_v |=> !frame_v);
endmodule

// File: rtl/qdac_reg_bank.sv
// Decodes complete frames into register writes and selects readback data.
// Assumes frame_v is a one-cycle pulse with frame_q valid in that cycle.
module qdac_reg_bank
    import qdac_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   frame_v,
    input  logic [FRAME_W-1:0]     frame_q,
    input  logic [DATA_W-1:0]      status_in,
    output logic [NCH*DATA_W-1:0]  data_o,
    output logic [NCH*DATA_W-1:0]  gain_o,
    output logic [NCH*DATA_W-1:0]  offset_o,
    output logic [NCH*PAY_W-1:0]   dac_ctrl_o,
    output logic [NCH*PAY_W-1:0]   slew_o,
    output logic [PAY_W-1:0]       main_o,
    output logic [PAY_W-1:0]       dcdc_o,
    output logic                   sw_pulse_o,
    output logic [PAY_W-1:0]       sw_val_o,
    output logic [DATA_W-1:0]      pend_o
);
    logic                 is_rd;
    logic                 is_wr;
    logic [ADDR_W-1:0]    addr;
    logic [DATA_W-1:0]    wdat;
    logic [2:0]           sel;
    logic [PAY_W-1:0]     pay;
    logic [CH_W-1:0]      rch;
    logic                 ctrl_hit;
    logic [DATA_W-1:0]    rd_word;
    logic                 unused_bits;

    logic [DATA_W-1:0] data_r [NCH];
    logic [DATA_W-1:0] gain_r [NCH];
    logic [DATA_W-1:0] offs_r [NCH];
    logic [PAY_W-1:0]  dac_r  [NCH];
    logic [PAY_W-1:0]  slew_r [NCH];
    logic [PAY_W-1:0]  main_r;
    logic [PAY_W-1:0]  dcdc_r;

    assign is_rd       = frame_q[RD_BIT];
    assign is_wr       = frame_v & ~is_rd;
    assign addr        = frame_q[ADDR_LSB +: ADDR_W];
    assign wdat        = frame_q[DATA_W-1:0];
    assign sel         = wdat[DATA_W-1:SEL_LSB];
    assign pay         = wdat[PAY_W-1:0];
    assign rch         = addr[CH_W-1:0];
    assign ctrl_hit    = is_wr && (addr[ADDR_W-1:CH_W] == WA_CTRL[ADDR_W-1:CH_W]);
    assign unused_bits = ^frame_q[RD_BIT-1:ADDR_LSB+ADDR_W];

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        // Per-channel storage updated by its own write addresses.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                data_r[c] <= '0;
                gain_r[c] <= '0;
                offs_r[c] <= '0;
                dac_r[c]  <= '0;
                slew_r[c] <= '0;
            end else if (is_wr) begin
                if (addr == ADDR_W'(c))             data_r[c] <= wdat;
                if (addr == (WA_GAIN | ADDR_W'(c))) gain_r[c] <= wdat;
                if (addr == (WA_OFFS | ADDR_W'(c))) offs_r[c] <= wdat;
                if (ctrl_hit && rch == CH_W'(c)) begin
                    if (sel == SUB_SLEW) slew_r[c] <= pay;
                    if (sel == SUB_DAC)  dac_r[c]  <= pay;
                end
            end
        end

        assign data_o[c*DATA_W +: DATA_W]    = data_r[c];
        assign gain_o[c*DATA_W +: DATA_W]    = gain_r[c];
        assign offset_o[c*DATA_W +: DATA_W]  = offs_r[c];
        assign dac_ctrl_o[c*PAY_W +: PAY_W]  = dac_r[c];
        assign slew_o[c*PAY_W +: PAY_W]      = slew_r[c];

        // R2: a code write lands in the addressed channel on the next cycle
        a_r2_code_write: assert property (@(posedge clk) disable iff (!rst_n)
            (frame_v && !frame_q[RD_BIT] && frame_q[ADDR_LSB +: ADDR_W] == ADDR_W'(c))
            |=> data_o[c*DATA_W +: DATA_W] == $past(frame_q[DATA_W-1:0]));
    end

    // Shared control words and the software strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            main_r     <= '0;
            dcdc_r     <= '0;
            sw_pulse_o <= 1'b0;
            sw_val_o   <= '0;
        end else begin
            sw_pulse_o <= 1'b0;
            if (ctrl_hit) begin
                if (sel == SUB_MAIN) main_r <= pay;
                if (sel == SUB_DCDC) dcdc_r <= pay;
                if (sel == SUB_SW) begin
                    sw_pulse_o <= 1'b1;
                    sw_val_o   <= pay;
                end
            end
        end
    end

    assign main_o = main_r;
    assign dcdc_o = dcdc_r;

    // Read-side address decode, grouped by the upper three address bits.
    always_comb begin
        rd_word = '0;
        case (addr[ADDR_W-1:CH_W])
            3'b000: rd_word = data_r[rch];
            3'b001: rd_word = DATA_W'(dac_r[rch]);
            3'b010: rd_word = gain_r[rch];
            3'b011: rd_word = offs_r[rch];
            3'b101: rd_word = DATA_W'(slew_r[rch]);
            3'b110: begin
                if (addr == RA_STATUS)    rd_word = status_in;
                else if (addr == RA_MAIN) rd_word = DATA_W'(main_r);
                else if (addr == RA_DCDC) rd_word = DATA_W'(dcdc_r);
            end
            default: rd_word = '0;
        endcase
    end

    // Pending reply: captured by a read, cleared by any other complete frame.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_o <= '0;
        else if (frame_v)
            pend_o <= is_rd ? rd_word : '0;
    end

    // R7: a complete write frame leaves nothing to return
    a_r7_pend_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_v && !frame_q[RD_BIT]) |=> pend_o == '0);

    // R8: the no-operation word touches no stored control value
    a_r8_nop_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_v && frame_q == NOP_WORD)
        |=> ($stable(dac_ctrl_o) && $stable(slew_o) && $stable(main_o)
             && $stable(dcdc_o) && !sw_pulse_o));

    // R4: the software strobe lasts exactly one cycle
    a_r4_sw_single: assert property (@(posedge clk) disable iff (!rst_n)
        sw_pulse_o |=> !sw_pulse_o);
endmodule

// File: rtl/qdac_spi_regs.sv
// Top: four-channel converter register slave on a mode-0 SPI link.
// Assumes sclk is slow relative to clk (see qdac_spi_sync) and cs_n
// returns high between frames.
module qdac_spi_regs
    import qdac_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sclk,
    input  logic                  cs_n,
    input  logic                  mosi,
    output logic                  miso,
    input  logic [DATA_W-1:0]     status_in,
    output logic [NCH*DATA_W-1:0] data_o,
    output logic [NCH*DATA_W-1:0] gain_o,
    output logic [NCH*DATA_W-1:0] offset_o,
    output logic [NCH*PAY_W-1:0]  dac_ctrl_o,
    output logic [NCH*PAY_W-1:0]  slew_o,
    output logic [PAY_W-1:0]      main_o,
    output logic [PAY_W-1:0]      dcdc_o,
    output logic                  sw_pulse_o,
    output logic [PAY_W-1:0]      sw_val_o
);
    logic               sclk_rise, sclk_fall, cs_act, cs_start, cs_end, mosi_s;
    logic               frame_v;
    logic [FRAME_W-1:0] frame_q;
    logic [DATA_W-1:0]  pend;
    logic [FRAME_W-1:0] tx_word;

    assign tx_word = {{(FRAME_W-DATA_W){1'b0}}, pend};

    qdac_spi_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (sclk),
        .cs_n      (cs_n),
        .mosi      (mosi),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_act    (cs_act),
        .cs_start  (cs_start),
        .cs_end    (cs_end),
        .mosi_s    (mosi_s)
    );

    qdac_frame_shift #(.FRAME_W(FRAME_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_act    (cs_act),
        .cs_start  (cs_start),
        .cs_end    (cs_end),
        .mosi_s    (mosi_s),
        .tx_word   (tx_word),
        .frame_v   (frame_v),
        .frame_q   (frame_q),
        .miso      (miso)
    );

    qdac_reg_bank u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_v    (frame_v),
        .frame_q    (frame_q),
        .status_in  (status_in),
        .data_o     (data_o),
        .gain_o     (gain_o),
        .offset_o   (offset_o),
        .dac_ctrl_o (dac_ctrl_o),
        .slew_o     (slew_o),
        .main_o     (main_o),
        .dcdc_o     (dcdc_o),
        .sw_pulse_o (sw_pulse_o),
        .sw_val_o   (sw_val_o),
        .pend_o     (pend)
    );
endmodule

// File: tb/qdac_spi_regs_tb.sv
// Bench: behavioural register model, serial host tasks, per-clock compare.
module qdac_spi_regs_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        sclk = 0;
    logic        cs_n = 1;
    logic        mosi = 0;
    logic        miso;
    logic [15:0] status_in = 16'hA5C3;
    logic [63:0] data_o, gain_o, offset_o;
    logic [51:0] dac_ctrl_o, slew_o;
    logic [12:0] main_o, dcdc_o, sw_val_o;
    logic        sw_pulse_o;

    int total = 0;
    int bad   = 0;
    bit cmp_en = 0;

    logic [15:0] m_data [4];
    logic [15:0] m_gain [4];
    logic [15:0] m_off  [4];
    logic [12:0] m_dac  [4];
    logic [12:0] m_slew [4];
    logic [12:0] m_main, m_dcdc, m_sw_last;
    int          m_sw_cnt;
    logic [15:0] m_pend;
    int          sw_cnt = 0;
    logic [12:0] sw_last = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    qdac_spi_regs u_dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .miso(miso), .status_in(status_in), .data_o(data_o), .gain_o(gain_o),
        .offset_o(offset_o), .dac_ctrl_o(dac_ctrl_o), .slew_o(slew_o),
        .main_o(main_o), .dcdc_o(dcdc_o), .sw_pulse_o(sw_pulse_o),
        .sw_val_o(sw_val_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (sw_pulse_o) begin
            sw_cnt  <= sw_cnt + 1;
            sw_last <= sw_val_o;
        end
    end

    // Per-clock compare of every register output against the model.
    always @(negedge clk) begin
        if (cmp_en) begin
            logic [63:0] e_d, e_g, e_o;
            logic [51:0] e_c, e_s;
            for (int c = 0; c < 4; c++) begin
                e_d[c*16 +: 16] = m_data[c];
                e_g[c*16 +: 16] = m_gain[c];
                e_o[c*16 +: 16] = m_off[c];
                e_c[c*13 +: 13] = m_dac[c];
                e_s[c*13 +: 13] = m_slew[c];
            end
            chk("R2 code", data_o, e_d);
            chk("R2 gain", gain_o, e_g);
            chk("R2 offset", offset_o, e_o);
            chk("R3 ctrl", 64'(dac_ctrl_o), 64'(e_c));
            chk("R3 slew", 64'(slew_o), 64'(e_s));
            chk("R3 main", 64'(main_o), 64'(m_main));
            chk("R3 dcdc", 64'(dcdc_o), 64'(m_dcdc));
            chk("R4 sw count", 64'(sw_cnt), 64'(m_sw_cnt));
            chk("R4 sw value", 64'(sw_last), 64'(m_sw_last));
        end
    end

    function automatic logic [15:0] m_read(input logic [4:0] a);
        int ia = int'(a);
        if (ia < 4)       return m_data[ia];
        else if (ia < 8)  return {3'b0, m_dac[ia-4]};
        else if (ia < 12) return m_gain[ia-8];
        else if (ia < 16) return m_off[ia-12];
        else if (ia < 20) return 16'h0;
        else if (ia < 24) return {3'b0, m_slew[ia-20]};
        else if (ia == 24) return status_in;
        else if (ia == 25) return {3'b0, m_main};
        else if (ia == 26) return {3'b0, m_dcdc};
        return 16'h0;
    endfunction

    task automatic m_apply(input logic [23:0] w);
        int ia = int'(w[20:16]);
        if (w[23]) begin
            m_pend = m_read(w[20:16]);
        end else begin
            m_pend = 16'h0;
            if (ia < 4) m_data[ia] = w[15:0];
            else if (ia >= 8 && ia < 12) m_gain[ia-8] = w[15:0];
            else if (ia >= 16 && ia < 20) m_off[ia-16] = w[15:0];
            else if (ia >= 28) begin
                case (w[15:13])
                    3'd0: m_slew[ia-28] = w[12:0];
                    3'd1: m_main = w[12:0];
                    3'd2: m_dac[ia-28] = w[12:0];
                    3'd3: m_dcdc = w[12:0];
                    3'd4: begin m_sw_cnt++; m_sw_last = w[12:0]; end
                    default: ;
                endcase
            end
        end
    endtask

    // One host transfer of nbits; checks the reply when the frame is complete.
    task automatic xfer(input logic [23:0] w, input int nbits, input string req);
        logic [23:0] got = '0;
        logic [23:0] exp;
        cmp_en = 0;
        @(negedge clk) cs_n = 0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            mosi = (i < 24) ? w[23-i] : 1'b0;
            repeat (HALF) @(negedge clk);
            if (i < 24) got = {got[22:0], miso};
            sclk = 1;
            repeat (HALF) @(negedge clk);
            sclk = 0;
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1;
        if (nbits == 24) begin
            exp = {8'h00, m_pend};
            chk(req, 64'(got), 64'(exp));
            m_apply(w);
        end
        repeat (10) @(negedge clk);
        cmp_en = 1;
    endtask

    initial begin
        for (int c = 0; c < 4; c++) begin
            m_data[c] = 0; m_gain[c] = 0; m_off[c] = 0; m_dac[c] = 0; m_slew[c] = 0;
        end
        m_main = 0; m_dcdc = 0; m_sw_last = 0; m_sw_cnt = 0; m_pend = 0;
        repeat (5) @(negedge clk);
        rst_n = 1;
        repeat (3) @(negedge clk);
        // R10: reset state and idle miso
        chk("R10 miso idle", 64'(miso), 64'h0);
        chk("R10 code reset", data_o, 64'h0);
        chk("R10 ctrl reset", 64'(dac_ctrl_o), 64'h0);
        cmp_en = 1;

        // R7: first frame after reset returns zero
        xfer(24'h1CE000, 24, "R7 first frame");
        // R2: per-channel code, gain and offset writes
        xfer(24'h001111, 24, "R7 after nop");
        xfer(24'h012222, 24, "R7 after write");
        xfer(24'h023333, 24, "R2");
        xfer(24'h03F00D, 24, "R2");
        xfer(24'h08ABCD, 24, "R2");
        xfer(24'h0B1234, 24, "R2");
        xfer(24'h118765, 24, "R2");
        xfer(24'h13FFFF, 24, "R2");
        xfer(24'h055555, 24, "R2 unmapped write");
        xfer(24'h0E5555, 24, "R2 unmapped write");
        // R1: bits 22:21 ignored
        xfer(24'h60BEEF, 24, "R1");
        // R3: control sub-writes
        xfer(24'h1D0ABC, 24, "R3");
        xfer(24'h1E5321, 24, "R3");
        xfer(24'h1F2FFF, 24, "R3");
        xfer(24'h1C7001, 24, "R3");
        // R4: software strobe and unused selects
        xfer(24'h1E8042, 24, "R4");
        xfer(24'h1DA111, 24, "R4");
        xfer(24'h1FC222, 24, "R4");
        // R5/R6: single reads collected by a no-operation
        xfer(24'h800000, 24, "R5");
        xfer(24'h1CE000, 24, "R5 code ch0");
        xfer(24'h860000, 24, "R5");
        xfer(24'h1CE000, 24, "R5 ctrl ch2");
        xfer(24'h8B0000, 24, "R5");
        xfer(24'h1CE000, 24, "R5 gain ch3");
        xfer(24'h8D0000, 24, "R5");
        xfer(24'h1CE000, 24, "R5 offset ch1");
        xfer(24'h950000, 24, "R5");
        xfer(24'h1CE000, 24, "R5 slew ch1");
        xfer(24'h980000, 24, "R5");
        xfer(24'h1CE000, 24, "R5 status");
        xfer(24'h990000, 24, "R5");
        xfer(24'h1CE000, 24, "R5 main");
        xfer(24'h9A0000, 24, "R5");
        xfer(24'h1CE000, 24, "R5 dcdc");
        // R11: clear and unmapped reads
        xfer(24'h920000, 24, "R11");
        xfer(24'h9F0000, 24, "R11 clear read");
        xfer(24'h1CE000, 24, "R11 unmapped read");
        // R6: pipelined reads
        xfer(24'h830000, 24, "R6");
        xfer(24'h8C0000, 24, "R6 pipe first");
        xfer(24'h970000, 24, "R6 pipe second");
        xfer(24'h1CE000, 24, "R6 pipe third");
        // R8: nop after nop returns zero
        xfer(24'h1CE000, 24, "R8 nop chain");
        // R9: short and long frames discarded, pending kept
        xfer(24'h810000, 24, "R9");
        xfer(24'h017777, 10, "R9");
        xfer(24'h027777, 26, "R9");
        xfer(24'h1CE000, 24, "R9 pending kept");
        // R7: read followed by write then collect
        xfer(24'h820000, 24, "R7");
        xfer(24'h02ABAB, 24, "R6 returned before write");
        xfer(24'h1CE000, 24, "R7 after write");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog act=hung exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule